// File: doc/BRIEF.md
# Fully Associative Read Cache with Rotating Victim Pointer

This block is a read-only cache of 64 blocks for a 32-bit byte address space. Each block holds 32 bytes. There is no set index. A lookup compares the address tag with the stored tag of every entry at the same time. The lowest-numbered valid entry whose tag matches supplies the answer. On a hit, the addressed 32-bit word comes back one cycle after the lookup, together with the number of the matching entry.

On a miss, the block raises a one-cycle fetch request toward a backing store. The request carries the block-aligned address. The block then waits for the store to return the whole block and writes it into the entry that the victim pointer names. It then returns the requested word.

The victim pointer is one register, not per-entry age state. It moves to the next entry, wrapping at the end, only when an access touches the entry it points at. A fill counts as such an access. The result is a cheap approximation of least-recently-used replacement.

The control is a three-state machine:
- `ST_IDLE` accepts lookups.
- `ST_REQ` drives the fetch request for one cycle.
- `ST_WAIT` holds until the block arrives.

The transitions are:
- T_HIT: `ST_IDLE` stays in `ST_IDLE` on a hit.
- T_MISS: `ST_IDLE` goes to `ST_REQ`.
- T_ISSUE: `ST_REQ` goes to `ST_WAIT`.
- T_HOLD: `ST_WAIT` stays in `ST_WAIT` while no response arrives.
- T_FILL: `ST_WAIT` returns to `ST_IDLE` when the response arrives.

Top module: `fa_cache_top`

## Requirements
- R1: After a synchronous reset:
  - `lk_ready` is 1, `rd_valid` is 0 and `mem_req_valid` is 0.
  - Every entry is invalid.
  - The victim pointer names entry 0, so the first fill goes to entry 0.
- R2: Address bits 31:5 are the tag and bits 4:2 select the word within the block. Bits 1:0 do not affect the result. Word w of a block sits at bits 32w+31 down to 32w of `mem_rsp_block`.
- R3: A lookup that is accepted (`lk_valid` and `lk_ready` both high) and hits a valid entry behaves as follows in the next cycle:
  - `rd_valid` is 1 and `rd_hit` is 1.
  - `rd_idx` is the matching entry.
  - `rd_data` is the selected word.
  - `lk_ready` stays 1.
- R4: An accepted lookup that misses behaves as follows:
  - In the next cycle, `lk_ready` drops to 0 and `mem_req_valid` is high for exactly one cycle.
  - `mem_req_addr` is the lookup address with bits 4:0 cleared.
  - One cycle after `mem_rsp_valid`, `rd_valid` is 1 with `rd_hit` 0 and the requested word.
- R5: A fill writes the block into the entry that the victim pointer names, reports that entry on `rd_idx`, and makes the entry valid, so a later lookup of the same block hits there.
- R6: When an access (a hit or a fill) touches the entry the victim pointer names, the pointer advances by one, wrapping from entry 63 to entry 0.
- R7: A hit on any entry other than the one the pointer names leaves the pointer unchanged.
- R8: Only valid entries hit. After reset, address 0 misses even though no tag has been written.
- R9: If several entries match, the lowest-numbered one is reported. Normal fills never create two matching entries.
- R10: A lookup presented while `lk_ready` is 0 is ignored: it produces no response and does not disturb the pending miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup byte address |
| lk_ready | output | 1 | High when a lookup can be accepted |
| rd_valid | output | 1 | Response valid, one cycle |
| rd_hit | output | 1 | 1 = response came from a hit, 0 = from a fill |
| rd_idx | output | 6 | Entry that hit or was filled |
| rd_data | output | 32 | Requested word |
| mem_req_valid | output | 1 | One-cycle block fetch request |
| mem_req_addr | output | 32 | Block-aligned fetch address |
| mem_rsp_valid | input | 1 | Fetched block is present |
| mem_rsp_block | input | 256 | Fetched block, word 0 in the low bits |

## Verification
The assertions assume the backing store returns exactly one response per fetch request. They also assume that response pulses `mem_rsp_valid` only while the machine waits, never in the same cycle as the request. The bench's responder raises the response two cycles after it observes the request, holds it for one cycle, and otherwise keeps it low. The bench also withdraws any lookup it presents during a pending miss before the machine returns to idle, so the stray request is never accepted.

// File: rtl/fa_pkg.sv
package fa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } fa_state_e;
endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 27,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0][TAG_W-1:0] ent_tag,
    input  logic [ENTRIES-1:0]            ent_valid,
    input  logic [TAG_W-1:0]              look_tag,
    output logic [ENTRIES-1:0]            match_vec,
    output logic                          hit,
    output logic [IDX_W-1:0]              hit_idx
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign match_vec[e] = ent_valid[e] && (ent_tag[e] == look_tag);
    end

    // Scan downward so the lowest matching entry is the last one written.
    always_comb begin
        hit_idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (match_vec[e]) hit_idx = IDX_W'(e);
        end
    end

    assign hit = |match_vec;
endmodule

// File: rtl/fa_repl_ptr.sv
module fa_repl_ptr #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (touch_en && (touch_idx == ptr)) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/fa_data_store.sv
module fa_data_store #(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 27,
    parameter int WORD_W  = 32,
    parameter int WSEL_W  = 3,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int BLK_W  = (1 << WSEL_W) * WORD_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          fill_en,
    input  logic [IDX_W-1:0]              fill_idx,
    input  logic [TAG_W-1:0]              fill_tag,
    input  logic [BLK_W-1:0]              fill_blk,
    input  logic [IDX_W-1:0]              rd_sel_idx,
    input  logic [WSEL_W-1:0]             rd_sel_w,
    output logic [WORD_W-1:0]             rd_word,
    output logic [ENTRIES-1:0][TAG_W-1:0] ent_tag,
    output logic [ENTRIES-1:0]            ent_valid
);
    logic [BLK_W-1:0] blk_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_valid <= '0;
        end else if (fill_en) begin
            ent_valid[fill_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            ent_tag[fill_idx] <= fill_tag;
            blk_q[fill_idx]   <= fill_blk;
        end
    end

    assign rd_word = blk_q[rd_sel_idx][rd_sel_w*WORD_W +: WORD_W];
endmodule

// File: rtl/fa_cache_top.sv
module fa_cache_top
    import fa_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 5,
    parameter int WORD_W  = 32,
    parameter int ENTRIES = 64,
    localparam int TAG_W  = ADDR_W - OFF_W,
    localparam int BYTE_W = $clog2(WORD_W / 8),
    localparam int WSEL_W = OFF_W - BYTE_W,
    localparam int BLK_W  = (1 << WSEL_W) * WORD_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_ready,
    output logic              rd_valid,
    output logic              rd_hit,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [BLK_W-1:0]  mem_rsp_block
);
    fa_state_e state_q, state_d;

    logic [TAG_W-1:0]              lk_tag;
    logic [WSEL_W-1:0]             lk_wsel;
    logic                          lk_unused_byte;
    logic [TAG_W-1:0]              pend_tag;
    logic [WSEL_W-1:0]             pend_wsel;
    logic [ENTRIES-1:0]            match_vec;
    logic                          look_hit;
    logic [IDX_W-1:0]              look_idx;
    logic [IDX_W-1:0]              repl_ptr;
    logic [ENTRIES-1:0][TAG_W-1:0] ent_tag;
    logic [ENTRIES-1:0]            ent_valid;
    logic [WORD_W-1:0]             store_word;
    logic [WORD_W-1:0]             fill_word;
    logic                          accept;
    logic                          fill_en;
    logic                          touch_en;
    logic [IDX_W-1:0]              touch_idx;

    assign lk_tag         = lk_addr[ADDR_W-1:OFF_W];
    assign lk_wsel        = lk_addr[OFF_W-1:BYTE_W];
    assign lk_unused_byte = ^lk_addr[BYTE_W-1:0];

    assign accept    = lk_valid && (state_q == ST_IDLE);
    assign fill_en   = (state_q == ST_WAIT) && mem_rsp_valid;
    assign touch_en  = (accept && look_hit) || fill_en;
    assign touch_idx = fill_en ? repl_ptr : look_idx;
    assign fill_word = mem_rsp_block[pend_wsel*WORD_W +: WORD_W];

    fa_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match (
        .ent_tag   (ent_tag),
        .ent_valid (ent_valid),
        .look_tag  (lk_tag),
        .match_vec (match_vec),
        .hit       (look_hit),
        .hit_idx   (look_idx)
    );

    fa_repl_ptr #(.ENTRIES(ENTRIES)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .ptr       (repl_ptr)
    );

    fa_data_store #(
        .ENTRIES (ENTRIES),
        .TAG_W   (TAG_W),
        .WORD_W  (WORD_W),
        .WSEL_W  (WSEL_W)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .fill_en    (fill_en),
        .fill_idx   (repl_ptr),
        .fill_tag   (pend_tag),
        .fill_blk   (mem_rsp_block),
        .rd_sel_idx (look_idx),
        .rd_sel_w   (lk_wsel),
        .rd_word    (store_word),
        .ent_tag    (ent_tag),
        .ent_valid  (ent_valid)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Transitions: T_HIT, T_MISS, T_ISSUE, T_HOLD, T_FILL
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && !look_hit) state_d = ST_REQ;
            ST_REQ:  state_d = ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign lk_ready      = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_REQ);
    assign mem_req_addr  = {pend_tag, {OFF_W{1'b0}}};

    // Registered outputs and the captured miss address
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid  <= 1'b0;
            rd_hit    <= 1'b0;
            rd_idx    <= '0;
            rd_data   <= '0;
            pend_tag  <= '0;
            pend_wsel <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (accept) begin
                pend_tag  <= lk_tag;
                pend_wsel <= lk_wsel;
            end
            if (accept && look_hit) begin
                rd_valid <= 1'b1;
                rd_hit   <= 1'b1;
                rd_idx   <= look_idx;
                rd_data  <= store_word;
            end else if (fill_en) begin
                rd_valid <= 1'b1;
                rd_hit   <= 1'b0;
                rd_idx   <= repl_ptr;
                rd_data  <= fill_word;
            end
        end
    end
endmodule

// File: rtl/fa_cache_chk.sv
module fa_cache_chk #(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 5,
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               rst,
    input logic               lk_valid,
    input logic               lk_ready,
    input logic               rd_valid,
    input logic               rd_hit,
    input logic               mem_req_valid,
    input logic [ADDR_W-1:0]  mem_req_addr,
    input logic               mem_rsp_valid,
    input logic [ENTRIES-1:0] match_vec,
    input logic               look_hit,
    input logic [IDX_W-1:0]   repl_ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0)); // R4
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid); // R4
    AST_REQ_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !lk_ready); // R4
    AST_HIT_RESP: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_ready && look_hit) |=> (rd_valid && rd_hit && lk_ready)); // R3
    AST_FILL_RESP: assert property (@(posedge clk) disable iff (rst)
        (mem_rsp_valid && !lk_ready && !mem_req_valid) |=> (rd_valid && !rd_hit && lk_ready)); // R4
    AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (rst)
        (!lk_ready && !mem_rsp_valid) |=> !rd_valid); // R10
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (repl_ptr != $past(repl_ptr)) |->
        (repl_ptr == (($past(repl_ptr) == LAST) ? '0 : $past(repl_ptr) + 1'b1))); // R6
    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $countones(match_vec) <= 1); // R9
endmodule

bind fa_cache_top fa_cache_chk #(
    .ADDR_W  (ADDR_W),
    .OFF_W   (OFF_W),
    .ENTRIES (ENTRIES)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .lk_valid      (lk_valid),
    .lk_ready      (lk_ready),
    .rd_valid      (rd_valid),
    .rd_hit        (rd_hit),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .match_vec     (match_vec),
    .look_hit      (look_hit),
    .repl_ptr      (repl_ptr)
);

// File: tb/sim_fa_cache_top.sv
`timescale 1ns/1ps
module sim_fa_cache_top;
    logic         clk = 1'b0;
    logic         rst;
    logic         lk_valid;
    logic [31:0]  lk_addr;
    logic         lk_ready;
    logic         rd_valid;
    logic         rd_hit;
    logic [5:0]   rd_idx;
    logic [31:0]  rd_data;
    logic         mem_req_valid;
    logic [31:0]  mem_req_addr;
    logic         mem_rsp_valid;
    logic [255:0] mem_rsp_block;

    int tests  = 0;
    int failed = 0;

    // Reference model built from the requirements
    logic [26:0] m_tag [64];
    logic        m_val [64];
    int          m_ptr;

    always #4 clk = ~clk;

    fa_cache_top u0 (
        .clk           (clk),
        .rst           (rst),
        .lk_valid      (lk_valid),
        .lk_addr       (lk_addr),
        .lk_ready      (lk_ready),
        .rd_valid      (rd_valid),
        .rd_hit        (rd_hit),
        .rd_idx        (rd_idx),
        .rd_data       (rd_data),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_block (mem_rsp_block)
    );

    function automatic logic [31:0] wval(input logic [26:0] t, input logic [2:0] w);
        return {w, t, 2'b00} ^ 32'h5A00_00C3;
    endfunction

    function automatic logic [255:0] mkblk(input logic [26:0] t);
        logic [255:0] b;
        for (int w = 0; w < 8; w++) b[w*32 +: 32] = wval(t, 3'(w));
        return b;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic m_advance(input int idx);
        if (idx == m_ptr) m_ptr = (m_ptr == 63) ? 0 : m_ptr + 1;
    endtask

    // One lookup; if stray is set, a second lookup is presented while the miss is pending.
    task automatic lookup(input logic [31:0] addr, input string req, input bit stray);
        logic [26:0] t;
        int hidx;
        t = addr[31:5];
        hidx = -1;
        for (int e = 63; e >= 0; e--) if (m_val[e] && m_tag[e] == t) hidx = e;
        @(negedge clk);
        lk_valid = 1'b1;
        lk_addr  = addr;
        @(negedge clk);
        lk_valid = 1'b0;
        if (hidx >= 0) begin
            chk(req, "hit rd_valid", 64'(rd_valid), 64'd1);
            chk(req, "hit rd_hit", 64'(rd_hit), 64'd1);
            chk(req, "hit rd_idx", 64'(rd_idx), 64'(hidx));
            chk(req, "hit rd_data", 64'(rd_data), 64'(wval(t, addr[4:2])));
            chk(req, "hit no fetch", 64'(mem_req_valid), 64'd0);
            m_advance(hidx);
        end else begin
            chk(req, "miss fetch", {mem_req_valid, lk_ready, rd_valid}, 64'b100);
            chk(req, "miss fetch addr", 64'(mem_req_addr), 64'({addr[31:5], 5'b0}));
            if (stray) begin
                lk_valid = 1'b1;
                lk_addr  = addr ^ 32'h0040_0000;
            end
            @(negedge clk);
            chk(req, "fetch pulse", 64'(mem_req_valid), 64'd0);
            @(negedge clk);
            lk_valid      = 1'b0;
            mem_rsp_valid = 1'b1;
            mem_rsp_block = mkblk(t);
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_block = '0;
            chk(req, "fill rd_valid", 64'(rd_valid), 64'd1);
            chk(req, "fill rd_hit", 64'(rd_hit), 64'd0);
            chk(req, "fill rd_idx", 64'(rd_idx), 64'(m_ptr));
            chk(req, "fill rd_data", 64'(rd_data), 64'(wval(t, addr[4:2])));
            m_tag[m_ptr] = t;
            m_val[m_ptr] = 1'b1;
            m_advance(m_ptr);
            @(negedge clk);
            chk(req, "single response", 64'(rd_valid), 64'd0);
        end
    endtask

    function automatic logic [31:0] baddr(input int b, input int w, input int by);
        return (32'(b * 13) << 5) | (32'(w) << 2) | 32'(by);
    endfunction

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "reset lk_ready", 64'(lk_ready), 64'd1);
        chk("R1", "reset rd_valid", 64'(rd_valid), 64'd0);
        chk("R1", "reset mem_req_valid", 64'(mem_req_valid), 64'd0);
    endtask

    task automatic t_cold();
        // Block 0 has tag 0, which matches the unwritten tags: must still miss (R8); fill to entry 0 (R1, R5)
        lookup(baddr(0, 3, 1), "R8", 1'b0);
    endtask

    task automatic t_words();
        for (int w = 0; w < 8; w++) lookup(baddr(0, 7 - w, w % 4), "R2", 1'b0);
    endtask

    task automatic t_fill_all();
        // Pointer is still 1 after hits to entry 0 (R7); entries 1..63 fill in order (R5)
        for (int b = 1; b < 64; b++) lookup(baddr(b, b % 8, 0), "R5", b == 10);
    endtask

    task automatic t_unique();
        // Every block reports its own entry: no duplicate matches (R9); pointer sits at 0 (R7)
        for (int b = 63; b >= 1; b--) lookup(baddr(b, 2, 3), "R9", 1'b0);
    endtask

    task automatic t_advance();
        lookup(baddr(0, 5, 0), "R6", 1'b0);          // hit on pointed entry 0 -> pointer 1
        lookup(32'h00FF_FF00 | 32'h14, "R6", 1'b0);  // new block goes to entry 1
        lookup(baddr(1, 4, 2), "R7", 1'b0);          // evicted block refills into entry 2
        lookup(baddr(1, 6, 0), "R3", 1'b0);          // now hits entry 2
    endtask

    task automatic t_stray_check();
        // The lookup presented during the pending miss of block 10 was never accepted (R10)
        chk("R10", "stray address", 64'(m_val[0] && m_tag[0] == baddr(10, 0, 0) >> 5), 64'd0);
        lookup(baddr(10, 1, 0) ^ 32'h0040_0000, "R10", 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        rst           = 1'b1;
        lk_valid      = 1'b0;
        lk_addr       = '0;
        mem_rsp_valid = 1'b0;
        mem_rsp_block = '0;
        m_ptr         = 0;
        for (int e = 0; e < 64; e++) begin
            m_tag[e] = '0;
            m_val[e] = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_cold();
        t_words();
        t_fill_all();
        t_unique();
        t_advance();
        t_stray_check();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule